// File: doc/BRIEF.md
# Break-Detecting Serial Receiver

This block receives asynchronous serial characters on a single line that idles high. A free-running tick strobe, pulsed sixteen times per bit period, paces it. Each character is a low start bit, then 8 or 9 data bits sent least significant first, then a high stop bit. Completed characters go into a receive data register, and the ninth bit goes into a separate output. Four sticky flags report status: receive-full, framing error, break and overrun. One clear strobe returns all four flags to zero and leaves the stored data as it is.

Besides ordinary characters, the receiver recognises a break, which is an unbroken run of low bit periods. The length of run that counts as a break depends on two settings: the word length and a long-break setting. A break sets receive-full, framing error and the break flag, and it zeroes the stored character. The receiver then waits for the line to return high before it looks for a new start bit.

The receive state machine has six states:
- `S_IDLE` watches for a low line.
- `S_START` re-checks the line half a bit later.
- `S_DATA` collects the data bits.
- `S_STOP` samples the stop position.
- `S_EXTRA` samples one additional bit in long-break mode.
- `S_WAIT_HIGH` holds off after a break.

Its transitions are:
- IDLE to START on a low sample.
- START back to IDLE when the line is high again at the half-bit point (a false start).
- START to DATA when the line is still low.
- DATA to STOP after the last data bit.
- STOP to IDLE on a high stop bit, or on a low stop bit when the data is not all zero.
- STOP to EXTRA on all zeros with long-break mode on.
- STOP to WAIT_HIGH on all zeros with long-break mode off.
- EXTRA to IDLE when the extra bit is high.
- EXTRA to WAIT_HIGH when the extra bit is low.
- WAIT_HIGH to IDLE once the line is sampled high.

Top module: `brk_uart_rx`

## Requirements
- R1: A low pulse on `rxd` that lasts less than half a bit period is ignored: no character is received and no flag changes.
- R2: When `word9`=0 a character has 8 data bits; when `word9`=1 it has 9. Bits arrive least significant first. When a character with a high stop bit completes, `rx_data` holds data bits 0..7 and `rx_bit9` holds data bit 8 (always 0 when `word9`=0). `rx_full` sets and `frame_err` stays clear.
- R3: A low stop bit after data that is not all zero sets `frame_err` and `rx_full`. The data is stored as in R2, and `brk_flag` stays clear.
- R4: With `long_brk`=0, a run of 10 (`word9`=0) or 11 (`word9`=1) consecutive low bit periods is a break. A break sets `brk_flag`, `frame_err` and `rx_full`. One bit period fewer, followed by a high bit, is an ordinary all-zero character with no error.
- R5: With `long_brk`=1, a break needs 11 (`word9`=0) or 12 (`word9`=1) consecutive low bit periods. One bit period fewer, followed by a high bit, stores a zero character with `frame_err` set and `brk_flag` clear.
- R6: A break sets `rx_data` and `rx_bit9` to zero.
- R7: A character that completes while `rx_full` is set sets `ovr_flag` and leaves `rx_data`, `rx_bit9` and `frame_err` unchanged. A break that completes while `rx_full` is set sets `ovr_flag` and also applies R4 and R6.
- R8: A one-cycle pulse on `clr_flags` clears `rx_full`, `frame_err`, `brk_flag` and `ovr_flag` and leaves `rx_data` and `rx_bit9` unchanged.
- R9: After a break the receiver ignores the line until it is sampled high. A low run far longer than a break therefore yields a single break and no overrun.
- R10: After reset every flag is clear and `rx_data` and `rx_bit9` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| long_brk | input | 1 | 1 lengthens the break threshold by one bit period |
| clr_flags | input | 1 | One-cycle strobe clearing all four status flags |
| rx_data | output | 8 | Received data bits 0..7 |
| rx_bit9 | output | 1 | Received data bit 8 |
| rx_full | output | 1 | Receive-full flag |
| frame_err | output | 1 | Framing error flag |
| brk_flag | output | 1 | Break flag |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The properties assume the following about the inputs:
- `tick` is a single-cycle pulse.
- `word9` and `long_brk` change only while the receiver is idle.
- A clear strobe never lands in the same cycle as a character completing. If it does, the set takes precedence, and the clear property excludes that cycle.

The stimulus keeps to these limits. Settings change only between characters, after several idle bit periods. `clr_flags` is pulsed only while the line is idle. Every bit on `rxd` is held for exactly sixteen ticks and changes away from the clock edge.

// File: rtl/brk_uart_rx_pkg.sv
package brk_uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_EXTRA,
        S_WAIT_HIGH
    } rx_state_t;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/rxb_fsm.sv
module rxb_fsm
    import brk_uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx_s,
    input  logic          word9,
    input  logic          long_brk,
    output logic          done,
    output logic [DW:0]   done_data,
    output logic          done_fe,
    output logic          done_brk
);
    localparam int NW   = DW + 1;
    localparam int CW   = $clog2(OVS);
    localparam int BCW  = $clog2(NW + 1);
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_t state, nxt;
    logic [CW-1:0]  tcnt;
    logic [BCW-1:0] bcnt;
    logic [NW-1:0]  shreg;
    logic [BCW-1:0] nbits;
    logic           mid, start_mid, last_bit, all_zero;
    logic [NW-1:0]  word_out;

    assign nbits     = word9 ? BCW'(NW) : BCW'(DW);
    assign mid       = tick && (tcnt == LAST);
    assign start_mid = tick && (tcnt == HALF);
    assign last_bit  = (bcnt == nbits - 1'b1);
    assign all_zero  = (shreg == '0);
    assign word_out  = word9 ? shreg : {1'b0, shreg[NW-1:1]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (tick && !rx_s) nxt = S_START;
            S_START:     if (start_mid) nxt = rx_s ? S_IDLE : S_DATA;
            S_DATA:      if (mid && last_bit) nxt = S_STOP;
            S_STOP:      if (mid) begin
                             if (rx_s || !all_zero) nxt = S_IDLE;
                             else if (long_brk)     nxt = S_EXTRA;
                             else                   nxt = S_WAIT_HIGH;
                         end
            S_EXTRA:     if (mid) nxt = rx_s ? S_IDLE : S_WAIT_HIGH;
            S_WAIT_HIGH: if (tick && rx_s) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bcnt      <= '0;
            shreg     <= '0;
            done      <= 1'b0;
            done_data <= '0;
            done_fe   <= 1'b0;
            done_brk  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == S_IDLE || state == S_WAIT_HIGH ||
                    (state == S_START && tcnt == HALF) || tcnt == LAST)
                    tcnt <= '0;
                else
                    tcnt <= tcnt + 1'b1;
            end
            unique case (state)
                S_START: if (start_mid) begin
                    shreg <= '0;
                    bcnt  <= '0;
                end
                S_DATA: if (mid) begin
                    shreg <= {rx_s, shreg[NW-1:1]};
                    bcnt  <= bcnt + 1'b1;
                end
                S_STOP: if (mid && (rx_s || !all_zero || !long_brk)) begin
                    done      <= 1'b1;
                    done_data <= word_out;
                    done_fe   <= !rx_s;
                    done_brk  <= !rx_s && all_zero;
                end
                S_EXTRA: if (mid) begin
                    done      <= 1'b1;
                    done_data <= '0;
                    done_fe   <= 1'b1;
                    done_brk  <= !rx_s;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/brk_uart_rx.sv
module brk_uart_rx #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              word9,
    input  logic              long_brk,
    input  logic              clr_flags,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_full,
    output logic              frame_err,
    output logic              brk_flag,
    output logic              ovr_flag
);
    logic          rx_s;
    logic          frm_done, frm_fe, frm_brk;
    logic [DATA_W:0] frm_data;

    rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    rxb_fsm #(.OVS(OVS), .DW(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
        .word9(word9), .long_brk(long_brk),
        .done(frm_done), .done_data(frm_data),
        .done_fe(frm_fe), .done_brk(frm_brk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            brk_flag  <= 1'b0;
            ovr_flag  <= 1'b0;
        end else begin
            if (clr_flags) begin
                rx_full   <= 1'b0;
                frame_err <= 1'b0;
                brk_flag  <= 1'b0;
                ovr_flag  <= 1'b0;
            end
            if (frm_done) begin
                if (frm_brk) begin
                    rx_data   <= '0;
                    rx_bit9   <= 1'b0;
                    rx_full   <= 1'b1;
                    frame_err <= 1'b1;
                    brk_flag  <= 1'b1;
                    if (rx_full) ovr_flag <= 1'b1;
                end else if (rx_full) begin
                    ovr_flag <= 1'b1;
                end else begin
                    rx_data   <= frm_data[DATA_W-1:0];
                    rx_bit9   <= frm_data[DATA_W];
                    rx_full   <= 1'b1;
                    frame_err <= frm_fe;
                end
            end
        end
    end
endmodule

// File: rtl/brk_uart_rx_chk.sv
module brk_uart_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          word9,
    input logic          clr_flags,
    input logic [DW-1:0] rx_data,
    input logic          rx_bit9,
    input logic          rx_full,
    input logic          frame_err,
    input logic          brk_flag,
    input logic          ovr_flag,
    input logic          frm_done,
    input logic          frm_brk
);
    p_brk_fe_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> frame_err && rx_full);

    p_brk_from_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(frm_done && frm_brk));

    p_brk_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> (rx_data == '0) && !rx_bit9);

    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && rx_full && !frm_brk |=> ovr_flag && $stable(rx_data) && $stable(rx_bit9));

    p_clr_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flags && !frm_done |=> !rx_full && !frame_err && !brk_flag && !ovr_flag);

    p_bit9_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !word9 && !rx_full |=> !rx_bit9);
endmodule

bind brk_uart_rx brk_uart_rx_chk #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word9(word9), .clr_flags(clr_flags),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
    .frame_err(frame_err), .brk_flag(brk_flag), .ovr_flag(ovr_flag),
    .frm_done(frm_done), .frm_brk(frm_brk)
);

// File: tb/brk_uart_rx_test.sv
module brk_uart_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       word9 = 1'b0;
    logic       long_brk = 1'b0;
    logic       clr_flags = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_full, frame_err, brk_flag, ovr_flag;

    int checks = 0;
    int failures = 0;
    localparam int BIT_CYC = 32;

    always #2 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    brk_uart_rx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .word9(word9), .long_brk(long_brk), .clr_flags(clr_flags),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
        .frame_err(frame_err), .brk_flag(brk_flag), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic status(input string req, input int d, input int b9, input int full,
                          input int fe, input int bk, input int ov);
        chk(req, "rx_data", int'(rx_data), d);
        chk(req, "rx_bit9", int'(rx_bit9), b9);
        chk(req, "rx_full", int'(rx_full), full);
        chk(req, "frame_err", int'(frame_err), fe);
        chk(req, "brk_flag", int'(brk_flag), bk);
        chk(req, "ovr_flag", int'(ovr_flag), ov);
    endtask

    task automatic bit_time(input logic b);
        rxd = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic stopb);
        bit_time(1'b0);
        for (int i = 0; i < (word9 ? 9 : 8); i++) bit_time(d[i]);
        bit_time(stopb);
        bit_time(1'b1);
        bit_time(1'b1);
    endtask

    task automatic send_low(input int n);
        repeat (n) bit_time(1'b0);
        repeat (3) bit_time(1'b1);
    endtask

    task automatic clear();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_all();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        status("R10", 0, 0, 0, 0, 0, 0);
        for (int w = 0; w < 2; w++) begin
            for (int lb = 0; lb < 2; lb++) begin
                logic [8:0] mask, d, d2;
                int nb, blen;
                word9 = w[0];
                long_brk = lb[0];
                mask = w[0] ? 9'h1FF : 9'h0FF;
                nb = w[0] ? 9 : 8;
                blen = nb + 2 + lb;
                repeat (4) bit_time(1'b1);
                clear();
                // R2: sweep of data values
                for (int k = 0; k < 16; k++) begin
                    d = 9'((k * 37 + 5) * 3) & mask;
                    send_frame(d, 1'b1);
                    status("R2", int'(d[7:0]), int'(d[8]), 1, 0, 0, 0);
                    clear();
                    status("R8", int'(d[7:0]), int'(d[8]), 0, 0, 0, 0);
                end
                // R3: low stop bit, nonzero data
                d = 9'h1A5 & mask;
                send_frame(d, 1'b0);
                status("R3", int'(d[7:0]), int'(d[8]), 1, 1, 0, 0);
                clear();
                // R4 / R5: one bit short of a break
                send_frame(mask, 1'b1);
                clear();
                send_low(blen - 1);
                if (lb == 0) status("R4", 0, 0, 1, 0, 0, 0);
                else         status("R5", 0, 0, 1, 1, 0, 0);
                clear();
                // R4 / R5 / R6: full break after nonzero preload
                send_frame(mask, 1'b1);
                clear();
                send_low(blen);
                status(lb == 0 ? "R4" : "R5", 0, 0, 1, 1, 1, 0);
                status("R6", 0, 0, 1, 1, 1, 0);
                clear();
                // R7: overrun on ordinary character, then on break
                d  = 9'h13C & mask;
                d2 = 9'h0C3 & mask;
                send_frame(d, 1'b1);
                send_frame(d2, 1'b1);
                status("R7", int'(d[7:0]), int'(d[8]), 1, 0, 0, 1);
                send_low(blen);
                status("R7", 0, 0, 1, 1, 1, 1);
                clear();
                // R9: very long low run gives one break, no overrun
                send_low(blen + 12);
                status("R9", 0, 0, 1, 1, 1, 0);
                clear();
                // R1: short glitch is ignored
                rxd = 1'b0;
                repeat (10) @(negedge clk);
                rxd = 1'b1;
                repeat (3 * BIT_CYC) @(negedge clk);
                status("R1", 0, 0, 0, 0, 0, 0);
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=hang expected=finish");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule